// File: doc/BRIEF.md
# Shift-Priority Loadable Shift Register

This block is a clocked storage word, four bits wide by default, that either moves its contents one place toward the least significant end, takes in a whole parallel word, or keeps what it holds. Two independent control inputs choose the operation. The shift control always wins: when both controls are high in the same cycle, the register shifts and the parallel word is not used.

During a shift, the serial input bit enters at the most significant position and the least significant bit drops out. The serial output always shows the current least significant bit, which is the bit that leaves on the next shift. A synchronous, active-high reset clears the word and overrides both controls. All decisions are made at the rising clock edge.

Top module: `shiftprio_loadreg`

## Requirements
- R1: When `rst` is 1 at a rising edge, `par_out` becomes all zeros after that edge, whatever `shift_en`, `load_en`, `ser_in` and `par_in` are.
- R2: When `shift_en` is 1 (and `rst` is 0), after the edge `par_out` equals {`ser_in`, old `par_out[W-1:1]`}. Bit W-1 is the most significant bit.
- R3: When `shift_en` and `load_en` are both 1, the register shifts as in R2 and `par_in` has no effect.
- R4: When `load_en` is 1 and `shift_en` is 0, after the edge `par_out` equals the `par_in` value sampled at that edge.
- R5: When both controls are 0, `par_out` stays unchanged, and `par_in` and `ser_in` have no effect.
- R6: `ser_out` always equals the present least significant bit of the stored word, so it is the bit that leaves on the next shift.
- R7: The width is the parameter `W`, with a default of 4. Each stored bit is a D flip-flop that updates only at the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| shift_en | input | 1 | Shift request; has priority over load |
| load_en | input | 1 | Parallel capture request |
| ser_in | input | 1 | Bit entering at the MSB during a shift |
| par_in | input | W | Parallel word to capture |
| par_out | output | W | Stored word |
| ser_out | output | 1 | Current LSB, the next bit to leave |

## Verification
The assertions assume that `rst` is high at the first clock edge, so every control input is known before any property is tested. They also assume that the controls and data are steady around each rising edge. The bench applies reset at time zero and changes every input two nanoseconds after a rising edge, well away from the next one. The bench also covers cases the assertions do not distinguish on their own: both controls high together, reset combined with both controls, and a value shifted fully out through `ser_out`.

// File: rtl/shiftprio_pkg.sv
package shiftprio_pkg;
  // Operation chosen for the coming clock edge, in priority order.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2,
    OP_CLEAR = 2'd3
  } sr_op_e;
endpackage

// File: rtl/sr_op_decode.sv
module sr_op_decode
  import shiftprio_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shift_en,
  input  logic   load_en,
  output sr_op_e op
);
  // Named events, exposed for the checks below.
  logic ev_clear, ev_shift, ev_load, ev_hold;

  assign ev_clear = rst;
  assign ev_shift = !rst && shift_en;
  assign ev_load  = !rst && !shift_en && load_en;
  assign ev_hold  = !rst && !shift_en && !load_en;

  always_comb begin
    if (ev_clear)      op = OP_CLEAR;
    else if (ev_shift) op = OP_SHIFT;
    else if (ev_load)  op = OP_LOAD;
    else               op = OP_HOLD;
  end

  // R3
  both_ctl_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_en && load_en) |-> (op == OP_SHIFT));

  // R1
  clear_wins_chk: assert property (@(posedge clk)
    rst |-> (op == OP_CLEAR && !ev_shift && !ev_load));
endmodule

// File: rtl/sr_next_word.sv
module sr_next_word
  import shiftprio_pkg::*;
#(
  parameter int W = 4
) (
  input  sr_op_e       op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  input  logic         sin,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] ZERO = '0;

  // One step toward the LSB; the new bit enters at the MSB.
  function automatic logic [W-1:0] step_right(input logic [W-1:0] v,
                                              input logic b);
    return {b, v[W-1:1]};
  endfunction

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = ZERO;
      OP_SHIFT: nxt = step_right(cur, sin);
      OP_LOAD:  nxt = din;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/sr_store.sv
module sr_store #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // R7: one D flip-flop per bit
  for (genvar i = 0; i < W; i++) begin : g_dff
    always_ff @(posedge clk) begin
      q[i] <= d[i];
    end
  end
endmodule

// File: rtl/shiftprio_loadreg.sv
module shiftprio_loadreg
  import shiftprio_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         load_en,
  input  logic         ser_in,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] par_out,
  output logic         ser_out
);
  sr_op_e       op;
  logic [W-1:0] next_word;

  sr_op_decode u_dec (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .load_en  (load_en),
    .op       (op)
  );

  sr_next_word #(.W(W)) u_nxt (
    .op  (op),
    .cur (par_out),
    .din (par_in),
    .sin (ser_in),
    .nxt (next_word)
  );

  sr_store #(.W(W)) u_reg (
    .clk (clk),
    .d   (next_word),
    .q   (par_out)
  );

  assign ser_out = par_out[0];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (par_out == '0));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (par_out == {$past(ser_in), $past(par_out[W-1:1])}));

  // R4
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (load_en && !shift_en) |=> (par_out == $past(par_in)));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !shift_en) |=> $stable(par_out));

  // R6
  leaving_bit_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ($past(ser_out) == $past(par_out[0])));
endmodule

// File: tb/shiftprio_loadreg_tb.sv
module shiftprio_loadreg_tb;
  localparam int W = 4;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_en = 1'b0;
  logic         load_en = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic [W-1:0] par_out;
  logic         ser_out;

  int n_vec = 0;
  int n_bad = 0;
  logic [W-1:0] model;

  always #4 clk = ~clk;

  shiftprio_loadreg #(.W(W)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .load_en  (load_en),
    .ser_in   (ser_in),
    .par_in   (par_in),
    .par_out  (par_out),
    .ser_out  (ser_out)
  );

  // {rst, shift, load, ser_in, par_in[3:0], expected par_out[3:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'b0010_1010_1010, // R4 load
    12'b0000_0101_1010, // R5 hold
    12'b0101_0000_1101, // R2 shift in 1
    12'b0110_1111_0110, // R3 both -> shift
    12'b0010_0011_0011, // R4 load
    12'b0100_0000_0001, // R2
    12'b0100_0000_0000, // R2
    12'b0001_1111_0000, // R5 inputs ignored
    12'b0010_1001_1001, // R4
    12'b1111_1111_0000, // R1 reset beats both
    12'b0101_0000_1000, // R2
    12'b0111_0000_1100  // R3 both -> shift
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic s, input logic l,
                       input logic si, input logic [W-1:0] d);
    rst = r; shift_en = s; load_en = l; ser_in = si; par_in = d;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // reset state, with load requested during reset (R1)
    drive(1'b1, 1'b0, 1'b1, 1'b1, 4'b1111);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 4'b1111);
    check("R1", par_out, 4'b0000);
    check("R6", {3'b000, ser_out}, 4'b0000);
    check("R7", W[3:0], 4'd4);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:4]);
      check("R1-R5 vector", par_out, VEC[i][3:0]);
      check("R6", {3'b000, ser_out}, {3'b000, VEC[i][0]});
    end

    // R6: load a pattern, shift it all out, and collect the leaving bits
    drive(1'b0, 1'b0, 1'b1, 1'b0, 4'b1011);
    model = '0;
    for (int k = 0; k < W; k++) begin
      model = {ser_out, model[W-1:1]};
      drive(1'b0, 1'b1, 1'b0, 1'b0, 4'b0000);
    end
    check("R6 drained bits", model, 4'b1011);
    check("R2 drained word", par_out, 4'b0000);

    // R3: both controls held for W cycles fill with ser_in, ignoring par_in
    for (int k = 0; k < W; k++) drive(1'b0, 1'b1, 1'b1, 1'b1, 4'b0101);
    check("R3 fill", par_out, 4'b1111);

    // R5: a long hold with changing data leaves the word alone
    for (int k = 0; k < 3; k++) drive(1'b0, 1'b0, 1'b0, k[0], k[3:0]);
    check("R5 long hold", par_out, 4'b1111);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule